// File: doc/BRIEF.md
# Interrupt Redirection Register Window

This block is the register front end of an I/O interrupt controller. Software reaches every internal register through two addresses. It first writes an 8-bit selector, and then reads or writes a 32-bit data window. Behind the window sit the following registers:

- a 4-bit identifier;
- a read-only version word;
- an arbitration word that mirrors the identifier;
- one 64-bit redirection entry per input pin, exposed as a low and a high 32-bit half.

A third address accepts end-of-interrupt notices written directly by software.

The block keeps the entries and publishes them to the delivery engine as a flat vector. It tells that engine when an entry has changed by pulsing a service request. It forwards direct end-of-interrupt vectors as a strobe.

The delivery engine owns two status bits in each entry:

- delivery-pending, which the block mirrors from an input;
- remote-IRR, which the engine sets and clears with pulses.

Software writes never change these two bits. The one exception is an entry left in edge mode, which always gets its remote-IRR cleared.

Top module: `intc_regwin`

## Requirements
- R1: After reset the selector reads 0, the identifier is 0, and every entry holds 0x0000_0000_0001_0000 (masked, all else zero). `svc_req`, `eoi_valid` and `acc_rdata` are 0.
- R2: Only the low 8 bits of `acc_addr` are decoded.
  - Offset 0x00 is the selector. Its writes take `acc_wdata[7:0]` at any size, and its reads return the selector in bits 7:0.
  - Offset 0x10 is the data window, and offset 0x40 is the direct end-of-interrupt register.
  - Reads of any other offset return 0, and writes to them have no effect.
  - Read data appears on `acc_rdata` in the cycle after `acc_rd`.
- R3: A window access whose `acc_size` is not 4 is ignored. Such a read returns 0, and such a write changes no state.
- R4: Selector 0x00 writes the identifier from bits 27:24. Selectors 0x00 and 0x02 both read the identifier in bits 27:24 with all other bits zero. Writes through selector 0x02 are ignored.
- R5: Selector 0x01 reads {8'h00, NPINS-1, 8'h00, VERSION}, which is 0x0017_0020 by default. Writes through it are ignored.
- R6: Selector values 0x10 and above address entry (sel-0x10)>>1. An odd selector reaches bits 63:32 and an even one reaches bits 31:0. Entry indexes at or beyond NPINS, and selectors 0x03 to 0x0F, read 0 and ignore writes.
- R7: Entry field access is split between software and the delivery engine.
  - Software can write bits 11:0, 13, 15 and 16 (low half) and bits 63:48 (high half). All other bits read 0, except bit 12 and bit 14.
  - Bit 12 (delivery-pending) follows `pend_status` with one cycle of lag.
  - Bit 14 (remote-IRR) is set by `rirr_set` and cleared by `rirr_clr`, and set wins over clear.
  - A write leaves bits 12 and 14 at the values these inputs give them.
- R8: When an entry write leaves trigger bit 15 at 0 (edge mode), remote-IRR reads 0 afterwards, even if `rirr_set` pulses in the same cycle. This holds for writes to either half.
- R9: `svc_req` is a one-cycle pulse in the cycle after every accepted entry-half write. It stays 0 for every other access.
- R10: When VERSION is 0x20, a 4-byte write to offset 0x40 pulses `eoi_valid` in the next cycle, with `eoi_vector` equal to `acc_wdata[7:0]`. Any other size, or VERSION 0x11, gives no pulse.
- R11: `ent_flat[64*i+63:64*i]` carries entry i to the delivery engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | ADDR_W | Byte address; low 8 bits decoded |
| acc_size | input | 4 | Access size in bytes |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid the cycle after `acc_rd` |
| pend_status | input | NPINS | Delivery-pending status per pin |
| rirr_set | input | NPINS | Remote-IRR set pulses |
| rirr_clr | input | NPINS | Remote-IRR clear pulses |
| svc_req | output | 1 | Entry changed, request a service pass |
| eoi_valid | output | 1 | Direct end-of-interrupt strobe |
| eoi_vector | output | 8 | Vector of the end-of-interrupt |
| ent_flat | output | NPINS*64 | All redirection entries |

## Verification
The delivery engine's remote-IRR pulse and a software write to the same entry can land in the same clock cycle. The bench drives `rirr_set` in the very cycle of an entry write, once with a level-mode value and once with an edge-mode value. It then reads the entry back through the window. A level-mode write must keep the freshly set bit 14, and an edge-mode write must read with bit 14 clear. A later write to the high half of an edge entry whose remote-IRR was set must also clear it.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    localparam int SEL_W  = 8;
    localparam int IDX_W  = SEL_W - 1;
    localparam int ENT_W  = 64;
    localparam int ID_LSB = 24;

    localparam logic [7:0] OFF_SEL = 8'h00;
    localparam logic [7:0] OFF_WIN = 8'h10;
    localparam logic [7:0] OFF_EOI = 8'h40;
    localparam logic [7:0] SEL_ENT_BASE = 8'h10;

    // entry bit positions decoded by the delivery engine
    localparam int B_PEND = 12;
    localparam int B_RIRR = 14;
    localparam int B_TRIG = 15;
    localparam int B_MASK = 16;

    localparam logic [ENT_W-1:0] ENT_RW_MASK = 64'hFFFF_0000_0001_AFFF;
    localparam logic [ENT_W-1:0] ENT_RST     = 64'h0000_0000_0001_0000;

    typedef enum logic [2:0] {
        K_ID, K_VER, K_ARB, K_ENT, K_NONE
    } win_kind_e;

    typedef struct packed {
        logic             at_sel;
        logic             at_win;
        logic             at_eoi;
        logic             size_ok;
        win_kind_e        kind;
        logic [IDX_W-1:0] idx;
        logic             hi;
    } dec_t;

    function automatic logic [ENT_W-1:0] merge_half(
        input logic [ENT_W-1:0] cur, input logic hi, input logic [31:0] d);
        logic [ENT_W-1:0] m;
        m = hi ? {d, cur[31:0]} : {cur[63:32], d};
        return m & ENT_RW_MASK;
    endfunction

endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
    import regwin_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NPINS  = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        size,
    input  logic [SEL_W-1:0]  sel,
    output dec_t              dec
);
    logic [7:0]       off;
    logic [SEL_W-1:0] rel;

    always_comb begin
        off         = addr[7:0];
        rel         = sel - SEL_ENT_BASE;
        dec.at_sel  = (off == OFF_SEL);
        dec.at_win  = (off == OFF_WIN);
        dec.at_eoi  = (off == OFF_EOI);
        dec.size_ok = (size == 4'd4);
        dec.idx     = rel[SEL_W-1:1];
        dec.hi      = sel[0];
        if (sel == 8'h00)
            dec.kind = K_ID;
        else if (sel == 8'h01)
            dec.kind = K_VER;
        else if (sel == 8'h02)
            dec.kind = K_ARB;
        else if (sel >= SEL_ENT_BASE && 32'(dec.idx) < NPINS)
            dec.kind = K_ENT;
        else
            dec.kind = K_NONE;
    end
endmodule

// File: rtl/regwin_entry_bank.sv
module regwin_entry_bank
    import regwin_pkg::*;
#(
    parameter int NPINS = 24
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [IDX_W-1:0]       idx,
    input  logic                   hi,
    input  logic [31:0]            wdata,
    input  logic [NPINS-1:0]       pend_status,
    input  logic [NPINS-1:0]       rirr_set,
    input  logic [NPINS-1:0]       rirr_clr,
    output logic [NPINS*ENT_W-1:0] ent_flat
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic [ENT_W-1:0] ent_q;
        logic [ENT_W-1:0] ent_d;
        logic [ENT_W-1:0] wval;
        logic             hit;
        logic             rirr_n;

        always_comb begin
            hit    = we && (32'(idx) == i);
            wval   = merge_half(ent_q, hi, wdata);
            rirr_n = rirr_set[i] ? 1'b1 : (rirr_clr[i] ? 1'b0 : ent_q[B_RIRR]);
            ent_d  = hit ? wval : ent_q;
            ent_d[B_PEND] = pend_status[i];
            ent_d[B_RIRR] = (hit && !wval[B_TRIG]) ? 1'b0 : rirr_n;
        end

        always_ff @(posedge clk) begin
            if (rst)
                ent_q <= ENT_RST;
            else
                ent_q <= ent_d;
        end

        assign ent_flat[i*ENT_W +: ENT_W] = ent_q;

        // R8: an edge-mode result of a write leaves remote-IRR clear
        p_edge_clear_r8: assert property (@(posedge clk) disable iff (rst)
            (we && 32'(idx) == i && !(hi ? ent_q[B_TRIG] : wdata[B_TRIG]))
            |=> !ent_q[B_RIRR]);

        // R7: a level-mode write with no status pulse keeps remote-IRR
        p_ro_hold_r7: assert property (@(posedge clk) disable iff (rst)
            (we && 32'(idx) == i && !rirr_set[i] && !rirr_clr[i]
             && (hi ? ent_q[B_TRIG] : wdata[B_TRIG]))
            |=> (ent_q[B_RIRR] == $past(ent_q[B_RIRR])));

        // R7: delivery-pending mirrors its input with one cycle lag
        p_pend_mirror_r7: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (ent_q[B_PEND] == $past(pend_status[i])));
    end
endmodule

// File: rtl/regwin_readmux.sv
module regwin_readmux
    import regwin_pkg::*;
#(
    parameter int         NPINS   = 24,
    parameter logic [7:0] VERSION = 8'h20
) (
    input  dec_t                   dec,
    input  logic [SEL_W-1:0]       sel,
    input  logic [3:0]             id,
    input  logic [NPINS*ENT_W-1:0] ent_flat,
    output logic [31:0]            rval
);
    localparam logic [7:0] MAX_PIN = 8'(NPINS - 1);

    logic [ENT_W-1:0] ent;

    always_comb begin
        ent  = '0;
        rval = '0;
        for (int i = 0; i < NPINS; i++)
            if (32'(dec.idx) == i)
                ent = ent_flat[i*ENT_W +: ENT_W];
        if (dec.at_sel) begin
            rval = {{(32-SEL_W){1'b0}}, sel};
        end else if (dec.at_win && dec.size_ok) begin
            unique case (dec.kind)
                K_ID, K_ARB: rval = {4'h0, id, 24'h0};
                K_VER:       rval = {8'h00, MAX_PIN, 8'h00, VERSION};
                K_ENT:       rval = dec.hi ? ent[63:32] : ent[31:0];
                default:     rval = '0;
            endcase
        end
    end
endmodule

// File: rtl/intc_regwin.sv
module intc_regwin
    import regwin_pkg::*;
#(
    parameter int         ADDR_W  = 12,
    parameter int         NPINS   = 24,
    parameter logic [7:0] VERSION = 8'h20
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      acc_addr,
    input  logic [3:0]             acc_size,
    input  logic                   acc_wr,
    input  logic                   acc_rd,
    input  logic [31:0]            acc_wdata,
    output logic [31:0]            acc_rdata,
    input  logic [NPINS-1:0]       pend_status,
    input  logic [NPINS-1:0]       rirr_set,
    input  logic [NPINS-1:0]       rirr_clr,
    output logic                   svc_req,
    output logic                   eoi_valid,
    output logic [7:0]             eoi_vector,
    output logic [NPINS*ENT_W-1:0] ent_flat
);
    localparam bit EOI_REG_PRESENT = (VERSION == 8'h20);

    logic [SEL_W-1:0] sel_q;
    logic [3:0]       id_q;
    dec_t             dec;
    logic [31:0]      rval;
    logic             win_ok;
    logic             ent_we;
    logic             eoi_we;

    regwin_decode #(.ADDR_W(ADDR_W), .NPINS(NPINS)) u_dec (
        .addr(acc_addr), .size(acc_size), .sel(sel_q), .dec(dec)
    );

    assign win_ok = acc_wr && dec.at_win && dec.size_ok;
    assign ent_we = win_ok && (dec.kind == K_ENT);
    assign eoi_we = EOI_REG_PRESENT && acc_wr && dec.at_eoi && dec.size_ok;

    regwin_entry_bank #(.NPINS(NPINS)) u_bank (
        .clk(clk), .rst(rst), .we(ent_we), .idx(dec.idx), .hi(dec.hi),
        .wdata(acc_wdata), .pend_status(pend_status),
        .rirr_set(rirr_set), .rirr_clr(rirr_clr), .ent_flat(ent_flat)
    );

    regwin_readmux #(.NPINS(NPINS), .VERSION(VERSION)) u_rmux (
        .dec(dec), .sel(sel_q), .id(id_q), .ent_flat(ent_flat), .rval(rval)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q      <= '0;
            id_q       <= '0;
            acc_rdata  <= '0;
            svc_req    <= 1'b0;
            eoi_valid  <= 1'b0;
            eoi_vector <= '0;
        end else begin
            if (acc_wr && dec.at_sel)
                sel_q <= acc_wdata[SEL_W-1:0];
            if (win_ok && dec.kind == K_ID)
                id_q <= acc_wdata[ID_LSB +: 4];
            acc_rdata <= acc_rd ? rval : '0;
            svc_req   <= ent_we;
            eoi_valid <= eoi_we;
            if (eoi_we)
                eoi_vector <= acc_wdata[7:0];
        end
    end

    // R9: every accepted entry write yields a service request
    p_svc_follows_r9: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && dec.at_win && dec.size_ok && dec.kind == K_ENT) |=> svc_req);

    // R10: an end-of-interrupt strobe only follows a write
    p_eoi_from_write_r10: assert property (@(posedge clk) disable iff (rst)
        eoi_valid |-> $past(acc_wr));

    // R3: a wrongly sized window read returns zero
    p_badsize_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (acc_rd && dec.at_win && !dec.size_ok) |=> (acc_rdata == 32'h0));

    // R9: service request is a single-cycle pulse unless writes continue
    p_svc_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        (svc_req && !acc_wr) |=> !svc_req);
endmodule

// File: tb/intc_regwin_tb.sv
module intc_regwin_tb;
    localparam int NPINS = 24;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [11:0]       acc_addr = '0;
    logic [3:0]        acc_size = 4'd4;
    logic              acc_wr = 1'b0;
    logic              acc_rd = 1'b0;
    logic [31:0]       acc_wdata = '0;
    logic [31:0]       acc_rdata;
    logic [NPINS-1:0]  pend_status = '0;
    logic [NPINS-1:0]  rirr_set = '0;
    logic [NPINS-1:0]  rirr_clr = '0;
    logic              svc_req;
    logic              eoi_valid;
    logic [7:0]        eoi_vector;
    logic [NPINS*64-1:0] ent_flat;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    intc_regwin u_dut (
        .clk(clk), .rst(rst), .acc_addr(acc_addr), .acc_size(acc_size),
        .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .pend_status(pend_status),
        .rirr_set(rirr_set), .rirr_clr(rirr_clr), .svc_req(svc_req),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .ent_flat(ent_flat)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [11:0] addr;
        logic [3:0]  size;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam logic [1:0] W = 2'd0;
    localparam logic [1:0] RD = 2'd1;
    localparam int NV = 34;

    localparam vec_t VECS [NV] = '{
        '{RD, 12'h000, 4'd4, 32'h0,        32'h0,        4'd1}, // R1 selector resets to 0
        '{W,  12'h000, 4'd1, 32'h10,       32'h0,        4'd2},
        '{RD, 12'h010, 4'd4, 32'h0,        32'h0001_0000, 4'd1}, // R1 entry reset masked
        '{W,  12'h010, 4'd4, 32'hFFFF_FFFF, 32'h0,       4'd7},
        '{RD, 12'h010, 4'd4, 32'h0,        32'h0001_AFFF, 4'd7}, // R7 writable low bits
        '{W,  12'hA00, 4'd4, 32'h11,       32'h0,        4'd2}, // R2 high addr bits dropped
        '{W,  12'h310, 4'd4, 32'h1234_5678, 32'h0,       4'd7},
        '{RD, 12'h010, 4'd4, 32'h0,        32'h1234_0000, 4'd7}, // R7 writable high bits
        '{RD, 12'hF00, 4'd2, 32'h0,        32'h0000_0011, 4'd2}, // R2 selector any size
        '{W,  12'h010, 4'd2, 32'h0,        32'h0,        4'd3},
        '{RD, 12'h010, 4'd2, 32'h0,        32'h0,        4'd3}, // R3 bad size read zero
        '{RD, 12'h010, 4'd4, 32'h0,        32'h1234_0000, 4'd3}, // R3 bad size write ignored
        '{W,  12'h000, 4'd4, 32'h00,       32'h0,        4'd4},
        '{W,  12'h010, 4'd4, 32'hFA00_0000, 32'h0,       4'd4},
        '{RD, 12'h010, 4'd4, 32'h0,        32'h0A00_0000, 4'd4}, // R4 id bits 27:24
        '{W,  12'h000, 4'd4, 32'h02,       32'h0,        4'd4},
        '{RD, 12'h010, 4'd4, 32'h0,        32'h0A00_0000, 4'd4}, // R4 arbitration mirrors id
        '{W,  12'h010, 4'd4, 32'h0500_0000, 32'h0,       4'd4},
        '{RD, 12'h010, 4'd4, 32'h0,        32'h0A00_0000, 4'd4}, // R4 arbitration read-only
        '{W,  12'h000, 4'd4, 32'h01,       32'h0,        4'd5},
        '{RD, 12'h010, 4'd4, 32'h0,        32'h0017_0020, 4'd5}, // R5 version word
        '{W,  12'h010, 4'd4, 32'hFFFF_FFFF, 32'h0,       4'd5},
        '{RD, 12'h010, 4'd4, 32'h0,        32'h0017_0020, 4'd5}, // R5 version read-only
        '{W,  12'h000, 4'd4, 32'h3F,       32'h0,        4'd6},
        '{W,  12'h010, 4'd4, 32'h8000_0000, 32'h0,       4'd6},
        '{RD, 12'h010, 4'd4, 32'h0,        32'h8000_0000, 4'd6}, // R6 last pin high half
        '{W,  12'h000, 4'd4, 32'h40,       32'h0,        4'd6},
        '{W,  12'h010, 4'd4, 32'hFFFF_FFFF, 32'h0,       4'd6},
        '{RD, 12'h010, 4'd4, 32'h0,        32'h0,        4'd6}, // R6 out of range index
        '{W,  12'h000, 4'd4, 32'h3E,       32'h0,        4'd6},
        '{RD, 12'h010, 4'd4, 32'h0,        32'h0001_0000, 4'd6}, // R6 even selects low half
        '{RD, 12'h020, 4'd4, 32'h0,        32'h0,        4'd2}, // R2 unused offset
        '{W,  12'h000, 4'd4, 32'h05,       32'h0,        4'd6},
        '{RD, 12'h010, 4'd4, 32'h0,        32'h0,        4'd6}  // R6 gap selector
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [3:0] s, input logic [31:0] d);
        @(negedge clk);
        acc_addr = a; acc_size = s; acc_wdata = d; acc_wr = 1'b1;
        @(negedge clk);
        acc_wr = 1'b0;
    endtask

    task automatic wr_set(input logic [31:0] d, input int pin);
        @(negedge clk);
        acc_addr = 12'h010; acc_size = 4'd4; acc_wdata = d; acc_wr = 1'b1;
        rirr_set[pin] = 1'b1;
        @(negedge clk);
        acc_wr = 1'b0; rirr_set = '0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [3:0] s, output logic [31:0] v);
        @(negedge clk);
        acc_addr = a; acc_size = s; acc_rd = 1'b1;
        @(negedge clk);
        acc_rd = 1'b0;
        v = acc_rdata;
    endtask

    task automatic pulse(input bit set, input int pin);
        @(negedge clk);
        if (set) rirr_set[pin] = 1'b1; else rirr_clr[pin] = 1'b1;
        @(negedge clk);
        rirr_set = '0; rirr_clr = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 svc_req idle", 64'(svc_req), 64'h0);
        check("R1 eoi_valid idle", 64'(eoi_valid), 64'h0);
        check("R1 rdata idle", 64'(acc_rdata), 64'h0);
        check("R1 pin5 reset entry", ent_flat[5*64 +: 64], 64'h0000_0000_0001_0000);

        for (int k = 0; k < NV; k++) begin
            if (VECS[k].op == W) begin
                wr(VECS[k].addr, VECS[k].size, VECS[k].data);
            end else begin
                rd(VECS[k].addr, VECS[k].size, v);
                check($sformatf("R%0d vector %0d", VECS[k].req, k), 64'(v), 64'(VECS[k].exp));
            end
        end

        // remote-IRR and delivery-pending ownership
        wr(12'h000, 4'd4, 32'h10);
        pulse(1'b1, 0);
        rd(12'h010, 4'd4, v); check("R7 rirr set by engine", 64'(v), 64'h0001_EFFF);
        wr(12'h010, 4'd4, 32'h0000_8000);
        check("R9 svc after entry write", 64'(svc_req), 64'h1);
        rd(12'h010, 4'd4, v); check("R7 rirr kept over write", 64'(v), 64'h0000_C000);
        check("R9 svc single pulse", 64'(svc_req), 64'h0);
        @(negedge clk); pend_status[0] = 1'b1;
        rd(12'h010, 4'd4, v); check("R7 pending mirrored", 64'(v), 64'h0000_D000);
        pend_status[0] = 1'b0;
        pulse(1'b0, 0);
        rd(12'h010, 4'd4, v); check("R7 rirr cleared by engine", 64'(v), 64'h0000_8000);

        // collisions of engine pulse with software write
        wr_set(32'h0000_0030, 0);
        rd(12'h010, 4'd4, v); check("R8 edge write beats set", 64'(v), 64'h0000_0030);
        check("R11 flat view pin0 low", ent_flat[31:0], 64'h0000_0030);
        wr_set(32'h0000_8000, 0);
        rd(12'h010, 4'd4, v); check("R7 level write keeps set", 64'(v), 64'h0000_C000);
        wr(12'h010, 4'd4, 32'h0000_0030);
        rd(12'h010, 4'd4, v); check("R8 edge write clears rirr", 64'(v), 64'h0000_0030);
        pulse(1'b1, 0);
        rd(12'h010, 4'd4, v); check("R7 set on edge entry", 64'(v), 64'h0000_4030);
        wr(12'h000, 4'd4, 32'h11);
        wr(12'h010, 4'd4, 32'h0);
        check("R9 svc on high half", 64'(svc_req), 64'h1);
        wr(12'h000, 4'd4, 32'h10);
        rd(12'h010, 4'd4, v); check("R8 high half write clears rirr", 64'(v), 64'h0000_0030);

        // non-entry writes and end-of-interrupt
        wr(12'h000, 4'd4, 32'h00);
        wr(12'h010, 4'd4, 32'h0100_0000);
        check("R9 no svc on id write", 64'(svc_req), 64'h0);
        wr(12'h040, 4'd4, 32'h0000_01A5);
        check("R10 eoi strobe", 64'(eoi_valid), 64'h1);
        check("R10 eoi vector", 64'(eoi_vector), 64'hA5);
        wr(12'h040, 4'd2, 32'h0000_0033);
        check("R10 short eoi ignored", 64'(eoi_valid), 64'h0);
        check("R11 flat view pin23 high", ent_flat[23*64+32 +: 32], 64'h8000_0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule